// File: doc/BRIEF.md
# Fail-Safe Clock Switchover Controller

This controller decides which clock source drives the system when an external oscillator may fail. It sits beside a separate failure detector. It arms that detector only while the external clock is in use. When the detector reports a failure, the controller moves the system onto an internal oscillator and latches an oscillator-fail flag. That flag can raise an interrupt. The internal frequency is taken from a software-programmed select field, so software can choose it before any fault occurs.

Getting back onto the external clock always goes through a start-up timer. The timer counts external clock ticks. It runs after reset and after every wake-up from sleep, unless the skip-timer mode is selected (for external-clock or RC modes). Software leaves fail-safe operation by toggling the clock-select bit or by entering sleep. The toggle restarts the timer, and the system keeps running on the internal clock until the timer expires. The fail flag cannot be cleared while fail-safe operation is still in force.

The control logic has four states. STARTUP runs the timer after reset or wake. EXTERNAL uses the external clock and arms the detector. FAILSAFE holds the internal clock after a fault. RESTART runs the timer after a select toggle. The transitions are:
- reset → STARTUP, or → EXTERNAL in skip mode
- STARTUP → EXTERNAL on timer expiry
- EXTERNAL → FAILSAFE on failure
- FAILSAFE → RESTART on select toggle, or → EXTERNAL in skip mode
- RESTART → EXTERNAL on expiry, and RESTART → RESTART (timer restarted) on a further toggle
- any state → STARTUP, or → EXTERNAL in skip mode, on a sleep request

Top module: `clk_failover_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) leaves the fail flag at 0 and int_freq at 0. It enters STARTUP when skip_ost is 0, giving use_internal=1, osc_stable=0 and mon_arm=0. It enters EXTERNAL directly when skip_ost is 1, giving use_internal=0, osc_stable=1 and mon_arm=1.
- R2: In STARTUP, only cycles with ext_tick=1 are counted. The clock edge that samples the OST_TICKS-th tick moves the controller to EXTERNAL, and no earlier edge does.
- R3: In EXTERNAL, fail_det=1 at an edge moves the controller to FAILSAFE (use_internal=1, mon_arm=0, osc_stable=0) and sets the fail flag. fail_det has no effect in any other state.
- R4: irq is 1 exactly when the fail flag and irq_en are both 1. It responds in the same cycle as irq_en changes.
- R5: int_freq is the value of ifreq_sel sampled at the previous clock edge.
- R6: flag_clr=1 clears the fail flag at the next edge only in STARTUP or EXTERNAL. It is ignored in FAILSAFE and RESTART. A failure set in the same cycle as a clear leaves the flag at 1.
- R7: A change of sel_ext compared with its value at the previous edge counts as a toggle. In FAILSAFE, a toggle enters RESTART with the timer at zero, or enters EXTERNAL directly in skip mode. RESTART expires into EXTERNAL after OST_TICKS ticks, as STARTUP does. Toggles in STARTUP and EXTERNAL are ignored.
- R8: A toggle in RESTART restarts the timer from zero, so OST_TICKS further ticks are needed before EXTERNAL.
- R9: sleep_req=1 in any state moves the controller to STARTUP with the timer at zero, or to EXTERNAL in skip mode. This ends fail-safe operation and leaves the fail flag unchanged.
- R10: mon_arm and osc_stable are 1 exactly in EXTERNAL, and use_internal is their complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fail_det | input | 1 | Failure indication from the oscillator monitor |
| ext_tick | input | 1 | One pulse per external oscillator tick |
| sel_ext | input | 1 | Clock-select control bit; any change counts as a toggle |
| sleep_req | input | 1 | Sleep entry request |
| flag_clr | input | 1 | Request to clear the fail flag |
| irq_en | input | 1 | Interrupt enable for the fail flag |
| skip_ost | input | 1 | Mode without start-up timer (external-clock or RC modes) |
| ifreq_sel | input | FREQ_W | Internal oscillator frequency select |
| use_internal | output | 1 | Clock source select: 1 = internal, 0 = external |
| int_freq | output | FREQ_W | Registered internal frequency code |
| osc_fail_flag | output | 1 | Oscillator-fail flag |
| irq | output | 1 | Interrupt request |
| osc_stable | output | 1 | Start-up complete and running on the external clock |
| mon_arm | output | 1 | Arms the external failure detector |

## Verification
The bench builds the controller with OST_TICKS=8 and FREQ_W=3. The short timer makes every timer path cheap to reach within a few dozen cycles: expiry after reset, after wake-up and after a toggle, and a restart partway through a count. These are the same counter paths that the 1024-tick default uses. The bench also applies a second reset with skip_ost high, which brings in the paths without a timer: reset, toggle and sleep all going straight to EXTERNAL.

// File: rtl/clk_failover_pkg.sv
package clk_failover_pkg;

    typedef enum logic [1:0] {
        ST_STARTUP  = 2'd0,
        ST_EXTERNAL = 2'd1,
        ST_FAILSAFE = 2'd2,
        ST_RESTART  = 2'd3
    } fo_state_e;

endpackage

// File: rtl/cfo_ost_timer.sv
module cfo_ost_timer #(
    parameter int TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);
    assign expired = run & tick & at_last & ~restart;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfo_sel_toggle.sv
module cfo_sel_toggle (
    input  logic clk,
    input  logic sel_in,
    output logic toggle
);
    logic sel_q;

    always_ff @(posedge clk) begin
        sel_q <= sel_in;
    end

    assign toggle = sel_in ^ sel_q;
endmodule

// File: rtl/cfo_fail_flag.sv
module cfo_fail_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic clr_ok,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr && clr_ok) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/clk_failover_ctrl.sv
module clk_failover_ctrl
    import clk_failover_pkg::*;
#(
    parameter int OST_TICKS = 1024,
    parameter int FREQ_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_det,
    input  logic              ext_tick,
    input  logic              sel_ext,
    input  logic              sleep_req,
    input  logic              flag_clr,
    input  logic              irq_en,
    input  logic              skip_ost,
    input  logic [FREQ_W-1:0] ifreq_sel,
    output logic              use_internal,
    output logic [FREQ_W-1:0] int_freq,
    output logic              osc_fail_flag,
    output logic              irq,
    output logic              osc_stable,
    output logic              mon_arm
);
    fo_state_e state_q, state_d;
    fo_state_e wake_state;
    logic      sel_toggle;
    logic      tmr_restart, tmr_run, tmr_expired;
    logic      flag_set, flag_clr_ok;

    cfo_sel_toggle u_toggle (
        .clk    (clk),
        .sel_in (sel_ext),
        .toggle (sel_toggle)
    );

    cfo_ost_timer #(.TICKS(OST_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .run     (tmr_run),
        .tick    (ext_tick),
        .expired (tmr_expired)
    );

    cfo_fail_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (flag_set),
        .clr    (flag_clr),
        .clr_ok (flag_clr_ok),
        .flag   (osc_fail_flag)
    );

    assign wake_state = skip_ost ? ST_EXTERNAL : ST_STARTUP;

    // timer control
    assign tmr_run     = (state_q == ST_STARTUP) || (state_q == ST_RESTART);
    assign tmr_restart = sleep_req
                       || ((state_q == ST_FAILSAFE) && sel_toggle && !skip_ost)
                       || ((state_q == ST_RESTART) && sel_toggle);

    // flag control
    assign flag_set    = (state_q == ST_EXTERNAL) && fail_det && !sleep_req;
    assign flag_clr_ok = (state_q == ST_STARTUP) || (state_q == ST_EXTERNAL);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= wake_state;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (sleep_req) begin
            state_d = wake_state;
        end else begin
            unique case (state_q)
                ST_STARTUP: begin
                    if (tmr_expired) state_d = ST_EXTERNAL;
                end
                ST_EXTERNAL: begin
                    if (fail_det) state_d = ST_FAILSAFE;
                end
                ST_FAILSAFE: begin
                    if (sel_toggle) state_d = skip_ost ? ST_EXTERNAL : ST_RESTART;
                end
                ST_RESTART: begin
                    if (tmr_expired) state_d = ST_EXTERNAL;
                end
                default: state_d = wake_state;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        use_internal = 1'b1;
        osc_stable   = 1'b0;
        mon_arm      = 1'b0;
        unique case (state_q)
            ST_EXTERNAL: begin
                use_internal = 1'b0;
                osc_stable   = 1'b1;
                mon_arm      = 1'b1;
            end
            ST_STARTUP, ST_FAILSAFE, ST_RESTART: begin
                use_internal = 1'b1;
            end
            default: use_internal = 1'b1;
        endcase
    end

    assign irq = osc_fail_flag & irq_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_freq <= '0;
        end else begin
            int_freq <= ifreq_sel;
        end
    end
endmodule

// File: rtl/clk_failover_chk.sv
module clk_failover_chk
    import clk_failover_pkg::*;
#(
    parameter int FREQ_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fail_det,
    input logic              sleep_req,
    input logic              skip_ost,
    input logic              irq_en,
    input logic              sel_toggle,
    input logic [FREQ_W-1:0] ifreq_sel,
    input logic              use_internal,
    input logic [FREQ_W-1:0] int_freq,
    input logic              osc_fail_flag,
    input logic              irq,
    input logic              osc_stable,
    input fo_state_e         state_q
);
    a_r3_fail_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stable && fail_det && !sleep_req) |=> (use_internal && osc_fail_flag));

    a_r3_no_set_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_stable && !osc_fail_flag) |=> !osc_fail_flag);

    a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (osc_fail_flag && irq_en));

    a_r5_freq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (int_freq == $past(ifreq_sel)));

    a_r6_clr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FAILSAFE || state_q == ST_RESTART) && osc_fail_flag) |=> osc_fail_flag);

    a_r7_toggle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILSAFE && sel_toggle && !sleep_req && !skip_ost) |=> (state_q == ST_RESTART));

    a_r7_failsafe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILSAFE && !sel_toggle && !sleep_req) |=> (state_q == ST_FAILSAFE));

    a_r9_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !skip_ost) |=> (state_q == ST_STARTUP && use_internal));
endmodule

bind clk_failover_ctrl clk_failover_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fail_det      (fail_det),
    .sleep_req     (sleep_req),
    .skip_ost      (skip_ost),
    .irq_en        (irq_en),
    .sel_toggle    (sel_toggle),
    .ifreq_sel     (ifreq_sel),
    .use_internal  (use_internal),
    .int_freq      (int_freq),
    .osc_fail_flag (osc_fail_flag),
    .irq           (irq),
    .osc_stable    (osc_stable),
    .state_q       (state_q)
);

// File: tb/test_clk_failover_ctrl.sv
module test_clk_failover_ctrl;
    localparam int N  = 8;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fail_det = 0, ext_tick = 0, sel_ext = 1, sleep_req = 0;
    logic flag_clr = 0, irq_en = 0, skip_ost = 0;
    logic [FW-1:0] ifreq_sel = 3'd2;
    logic use_internal, osc_fail_flag, irq, osc_stable, mon_arm;
    logic [FW-1:0] int_freq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model: 0 startup, 1 external, 2 failsafe, 3 restart
    int m_st = 0, m_cnt = 0;
    bit m_flag = 0, m_selq = 1;
    int m_freq = 0;

    always #5 clk = ~clk;

    clk_failover_ctrl #(.OST_TICKS(N), .FREQ_W(FW)) i_clk_failover_ctrl (
        .clk(clk), .rst_n(rst_n), .fail_det(fail_det), .ext_tick(ext_tick),
        .sel_ext(sel_ext), .sleep_req(sleep_req), .flag_clr(flag_clr),
        .irq_en(irq_en), .skip_ost(skip_ost), .ifreq_sel(ifreq_sel),
        .use_internal(use_internal), .int_freq(int_freq),
        .osc_fail_flag(osc_fail_flag), .irq(irq), .osc_stable(osc_stable),
        .mon_arm(mon_arm)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit tog, restart, timed, expire;
        int nst;
        if (!rst_n) begin
            m_st = skip_ost ? 1 : 0; m_cnt = 0; m_flag = 0; m_freq = 0; m_selq = sel_ext;
            return;
        end
        tog = (sel_ext != m_selq);
        timed = (m_st == 0 || m_st == 3);
        nst = m_st;
        restart = 0;
        if (sleep_req) begin
            nst = skip_ost ? 1 : 0; restart = 1;
        end else if (m_st == 2 && tog) begin
            if (skip_ost) nst = 1; else begin nst = 3; restart = 1; end
        end else if (m_st == 3 && tog) begin
            restart = 1;
        end else if (m_st == 1 && fail_det) begin
            nst = 2;
        end
        expire = timed && !restart && ext_tick && (m_cnt == N - 1);
        if (expire) nst = 1;
        if (restart) m_cnt = 0;
        else if (timed && ext_tick) m_cnt = expire ? 0 : m_cnt + 1;
        if (m_st == 1 && fail_det && !sleep_req) m_flag = 1;
        else if (flag_clr && (m_st == 0 || m_st == 1)) m_flag = 0;
        m_st = nst;
        m_freq = ifreq_sel;
        m_selq = sel_ext;
    endtask

    task automatic compare();
        chk("R10 use_internal", use_internal, m_st != 1);
        chk("R10 osc_stable", osc_stable, m_st == 1);
        chk("R10 mon_arm", mon_arm, m_st == 1);
        chk("R6 flag", osc_fail_flag, m_flag);
        chk("R4 irq", irq, m_flag && irq_en);
        chk("R5 int_freq", int_freq, m_freq);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        #1;
        compare();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            ext_tick = 1; step(); ext_tick = 0; step();
        end
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step(); step();
        rst_n = 1;
        #1;
        chk("R1 use_internal", use_internal, 1);
        chk("R1 osc_stable", osc_stable, 0);
        chk("R1 mon_arm", mon_arm, 0);
        chk("R1 flag", osc_fail_flag, 0);
        chk("R1 int_freq", int_freq, 0);

        fail_det = 1; step(); fail_det = 0;
        chk("R3 disarmed fail ignored", osc_fail_flag, 0);

        ticks(N - 1);
        chk("R2 not yet expired", osc_stable, 0);
        ext_tick = 1; step(); ext_tick = 0;
        chk("R2 expiry to external", osc_stable, 1);
        chk("R2 external selected", use_internal, 0);

        irq_en = 1; ifreq_sel = 3'd5;
        fail_det = 1; step(); fail_det = 0;
        chk("R3 switch internal", use_internal, 1);
        chk("R3 flag set", osc_fail_flag, 1);
        chk("R3 disarm", mon_arm, 0);
        chk("R4 irq raised", irq, 1);
        chk("R5 freq captured", int_freq, 5);
        irq_en = 0; #1;
        chk("R4 irq masked", irq, 0);
        step();

        flag_clr = 1; step(); flag_clr = 0;
        chk("R6 clear ignored in failsafe", osc_fail_flag, 1);

        sel_ext = 0; step();
        chk("R7 restart keeps internal", use_internal, 1);
        ticks(3);
        sel_ext = 1; step();
        ticks(N - 1);
        chk("R8 count restarted", osc_stable, 0);
        flag_clr = 1; step(); flag_clr = 0;
        chk("R6 clear ignored in restart", osc_fail_flag, 1);
        ext_tick = 1; step(); ext_tick = 0;
        chk("R8 expiry after restart", osc_stable, 1);

        flag_clr = 1; step(); flag_clr = 0;
        chk("R6 clear in external", osc_fail_flag, 0);

        sel_ext = 0; step();
        chk("R7 toggle ignored in external", osc_stable, 1);

        fail_det = 1; flag_clr = 1; step(); fail_det = 0; flag_clr = 0;
        chk("R6 set wins over clear", osc_fail_flag, 1);
        sleep_req = 1; step(); sleep_req = 0;
        chk("R9 sleep to startup", osc_stable, 0);
        chk("R9 flag kept", osc_fail_flag, 1);
        ticks(N);
        chk("R9 wake timer expiry", osc_stable, 1);

        skip_ost = 1; rst_n = 0; step(); step(); rst_n = 1;
        #1;
        chk("R1 skip mode external", osc_stable, 1);
        chk("R1 skip mode armed", mon_arm, 1);
        fail_det = 1; step(); fail_det = 0;
        chk("R3 fail in skip mode", use_internal, 1);
        sel_ext = ~sel_ext; step();
        chk("R7 skip toggle to external", osc_stable, 1);
        fail_det = 1; step(); fail_det = 0;
        sleep_req = 1; step(); sleep_req = 0;
        chk("R9 skip sleep to external", osc_stable, 1);
        step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule